// File: doc/BRIEF.md
# Sixteen-Operation ALU with Flags

A purely combinational 32-bit arithmetic and logic unit for a small register machine. The first operand is always the destination-register value. The second operand is either the second register value or a zero-extended 8-bit immediate. A 4-bit operation code selects one of sixteen functions: bitwise logic, add, add with carry, subtract, sign-extend of a byte, logical shifts, a right rotate, and three flag-only operations (bit test, equivalence test, compare).

The unit returns the result and a write-enable for the destination register. It also returns next values for the negative (N), zero (Z) and carry (C) flags, each with its own update enable. When C is not updated, the carry output simply repeats the incoming carry. An immediate mode replaces the 4-bit code with a 2-bit code that reaches four of the operations: move, compare, add and subtract.

The surrounding datapath owns the register file, the flag register, decode and memory. It latches whatever the enables allow.

Top module: `alu_flags`

## Requirements
- R1: With immediate mode off, codes 0000 (Rd AND Rn), 0001 (Rd XOR Rn), 1100 (Rd OR Rn), 1110 (Rd AND NOT Rn), 1101 (Rn) and 1111 (NOT Rn) produce that value with `rd_we`=1 and `c_we`=0.
- R2: Code 0100 gives Rd+Rn and code 0101 gives Rd+Rn+carry_in. Both write Rd and set `c_we`=1, with C equal to the carry out of bit 31.
- R3: Code 0010 gives Rd−Rn with `rd_we`=1 and `c_we`=1. C is 1 exactly when Rd ≥ Rn as unsigned numbers (no borrow).
- R4: Code 0011 writes the sign-extended low byte of Rn (bit 7 copied into bits 31..8), with `c_we`=0.
- R5: Codes 1000 (AND), 1001 (XOR) and 1010 (subtract) hold `rd_we`=0. Their flags are computed on the discarded value, and C is updated only by 1010, following the R3 rule.
- R6: `flag_n` equals bit 31 of `result` and `flag_z` is 1 exactly when `result` is zero. `n_we` and `z_we` are always 1.
- R7: Code 0110 shifts Rd right by the amount, filling with zeros. C is the last bit shifted out of bit 0.
- R8: Code 0111 shifts Rd left by the amount, filling with zeros. C is the last bit shifted out of bit 31.
- R9: Code 1011 rotates Rd right by the amount. C is the last bit rotated out, which is bit 31 of the result.
- R10: The shift and rotate amount is Rn[4:0]; higher bits of Rn are ignored. An amount of zero returns Rd unchanged and keeps `flag_c` equal to `carry_in`.
- R11: With `imm_mode`=1, `imm_code` 00 moves, 01 compares, 10 adds and 11 subtracts. The second operand is `imm_val` zero-extended, and `op_code` is ignored.
- R12: An immediate move has `c_we`=0. An immediate compare, add or subtract has `c_we`=1. An immediate compare has `rd_we`=0.
- R13: Whenever `c_we`=0, `flag_c` equals `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Register-form operation code |
| imm_mode | input | 1 | Select immediate form |
| imm_code | input | 2 | Immediate-form operation code |
| imm_val | input | 8 | Immediate value, zero-extended |
| rd_val | input | 32 | Destination-register value (first operand) |
| rn_val | input | 32 | Second-register value |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Operation result |
| rd_we | output | 1 | Write result to Rd |
| flag_n | output | 1 | Next negative flag |
| flag_z | output | 1 | Next zero flag |
| flag_c | output | 1 | Next carry flag |
| n_we | output | 1 | Update N |
| z_we | output | 1 | Update Z |
| c_we | output | 1 | Update C |

## Verification
Every output is due in the same cycle as its inputs, because there is no register between the operands and the results. The bench drives a new operand set just after a rising edge and compares all eight outputs at the following falling edge, once the combinational paths have settled. The expected values come from a behavioural model that works in 64-bit integers and shifts one bit at a time to track carry. Directed vectors cover the shift amounts 0, 1 and 31, borrow against no-borrow, zero results and the immediate codes. A random sweep then exercises the whole code space.

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W    = 32,
  parameter int IMMW = 8
) (
  input  logic [3:0]      op_code,
  input  logic            imm_mode,
  input  logic [1:0]      imm_code,
  input  logic [IMMW-1:0] imm_val,
  input  logic [W-1:0]    rd_val,
  input  logic [W-1:0]    rn_val,
  input  logic            carry_in,
  output logic [W-1:0]    result,
  output logic            rd_we,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_c,
  output logic            n_we,
  output logic            z_we,
  output logic            c_we
);
  localparam int SW = $clog2(W);

  logic [3:0]    op;
  logic [W-1:0]  opb;
  logic [SW-1:0] amt, lsr_idx, lsl_idx;
  logic [W:0]    sum, diff;
  logic [W-1:0]  lsr_v, lsl_v, ror_v;
  logic [W-1:0]  res;
  logic          we, cupd, cnew;

  always_comb begin
    case (imm_code)
      2'b00:   op = 4'b1101;
      2'b01:   op = 4'b1010;
      2'b10:   op = 4'b0100;
      default: op = 4'b0010;
    endcase
    if (!imm_mode) op = op_code;
  end

  assign opb     = imm_mode ? {{(W-IMMW){1'b0}}, imm_val} : rn_val;
  assign amt     = opb[SW-1:0];
  assign lsr_idx = amt - SW'(1);
  assign lsl_idx = SW'(W - int'(amt));

  assign sum  = {1'b0, rd_val} + {1'b0, opb} + {{W{1'b0}}, (op == 4'b0101) & carry_in};
  assign diff = {1'b0, rd_val} + {1'b0, ~opb} + (W+1)'(1);

  assign lsr_v = rd_val >> amt;
  assign lsl_v = rd_val << amt;
  assign ror_v = (rd_val >> amt) | (rd_val << (W - int'(amt)));

  always_comb begin
    res  = '0;
    we   = 1'b1;
    cupd = 1'b0;
    cnew = carry_in;
    case (op)
      4'b0000: res = rd_val & opb;
      4'b0001: res = rd_val ^ opb;
      4'b0010: begin res = diff[W-1:0]; cupd = 1'b1; cnew = diff[W]; end
      4'b0011: res = {{(W-8){opb[7]}}, opb[7:0]};
      4'b0100: begin res = sum[W-1:0]; cupd = 1'b1; cnew = sum[W]; end
      4'b0101: begin res = sum[W-1:0]; cupd = 1'b1; cnew = sum[W]; end
      4'b0110: begin
        res  = lsr_v;
        cupd = 1'b1;
        if (amt != '0) cnew = rd_val[lsr_idx];
      end
      4'b0111: begin
        res  = lsl_v;
        cupd = 1'b1;
        if (amt != '0) cnew = rd_val[lsl_idx];
      end
      4'b1000: begin res = rd_val & opb; we = 1'b0; end
      4'b1001: begin res = rd_val ^ opb; we = 1'b0; end
      4'b1010: begin res = diff[W-1:0]; we = 1'b0; cupd = 1'b1; cnew = diff[W]; end
      4'b1011: begin
        res  = ror_v;
        cupd = 1'b1;
        if (amt != '0) cnew = ror_v[W-1];
      end
      4'b1100: res = rd_val | opb;
      4'b1101: res = opb;
      4'b1110: res = rd_val & ~opb;
      4'b1111: res = ~opb;
    endcase
  end

  assign result = res;
  assign rd_we  = we;
  assign flag_n = res[W-1];
  assign flag_z = (res == '0);
  assign flag_c = cupd ? cnew : carry_in;
  assign n_we   = 1'b1;
  assign z_we   = 1'b1;
  assign c_we   = cupd;
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
  parameter int W    = 32,
  parameter int IMMW = 8
) (
  input logic [3:0]      op_code,
  input logic            imm_mode,
  input logic [1:0]      imm_code,
  input logic [IMMW-1:0] imm_val,
  input logic [W-1:0]    rd_val,
  input logic [W-1:0]    rn_val,
  input logic            carry_in,
  input logic [W-1:0]    result,
  input logic            rd_we,
  input logic            flag_n,
  input logic            flag_z,
  input logic            flag_c,
  input logic            n_we,
  input logic            z_we,
  input logic            c_we
);
  always_comb begin
    // R5
    flagonly_nowb_chk: assert (imm_mode || !(op_code inside {4'b1000, 4'b1001, 4'b1010}) || !rd_we)
      else $error("flag-only op wrote Rd");
    // R6
    zero_flag_chk: assert (flag_z == (result == '0))
      else $error("Z mismatch");
    // R6
    neg_flag_chk: assert (flag_n == result[W-1] && n_we && z_we)
      else $error("N mismatch");
    // R13
    carry_hold_chk: assert (c_we || flag_c == carry_in)
      else $error("C changed without update");
    // R12
    imm_mov_chk: assert (!(imm_mode && imm_code == 2'b00) ||
                         (result == {{(W-IMMW){1'b0}}, imm_val} && !c_we && rd_we))
      else $error("immediate move wrong");
    // R1
    logic_nocarry_chk: assert (imm_mode || !(op_code inside {4'b0000, 4'b0001, 4'b1100, 4'b1101, 4'b1110, 4'b1111}) || !c_we)
      else $error("logic op touched C");
    // R10
    shift_zero_chk: assert (imm_mode || !(op_code inside {4'b0110, 4'b0111, 4'b1011}) ||
                            rn_val[$clog2(W)-1:0] != '0 || (result == rd_val && flag_c == carry_in))
      else $error("zero shift altered value");
  end
endmodule

bind alu_flags alu_flags_chk #(.W(W), .IMMW(IMMW)) u_chk (.*);

// File: tb/tb_alu_flags.sv
module tb_alu_flags;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]  op_code = '0;
  logic        imm_mode = 1'b0;
  logic [1:0]  imm_code = '0;
  logic [7:0]  imm_val = '0;
  logic [31:0] rd_val = '0, rn_val = '0;
  logic        carry_in = 1'b0;
  logic [31:0] result;
  logic        rd_we, flag_n, flag_z, flag_c, n_we, z_we, c_we;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  alu_flags dut (.*);

  task automatic model(output logic [31:0] r, output bit we, output bit c, output bit cw);
    int o;
    longint a, b, t;
    int s;
    a = longint'(rd_val);
    b = imm_mode ? longint'(imm_val) : longint'(rn_val);
    if (imm_mode) o = (imm_code == 0) ? 13 : (imm_code == 1) ? 10 : (imm_code == 2) ? 4 : 2;
    else o = int'(op_code);
    s = int'(b & 31);
    we = 1; c = carry_in; cw = 0; r = 0;
    case (o)
      0: r = 32'(a & b);
      1: r = 32'(a ^ b);
      2, 10: begin r = 32'(a - b); c = (a >= b); cw = 1; we = (o == 2); end
      3: begin t = b & 255; if (t >= 128) t = t - 256; r = 32'(t); end
      4, 5: begin t = a + b + ((o == 5 && carry_in) ? 1 : 0); r = 32'(t); c = t[32]; cw = 1; end
      6: begin r = rd_val; cw = 1; for (int i = 0; i < s; i++) begin c = r[0]; r = r >> 1; end end
      7: begin r = rd_val; cw = 1; for (int i = 0; i < s; i++) begin c = r[31]; r = r << 1; end end
      8: begin r = 32'(a & b); we = 0; end
      9: begin r = 32'(a ^ b); we = 0; end
      11: begin r = rd_val; cw = 1; for (int i = 0; i < s; i++) begin c = r[0]; r = {r[0], r[31:1]}; end end
      12: r = 32'(a | b);
      13: r = 32'(b);
      14: r = 32'(a & ~b);
      default: r = ~32'(b);
    endcase
  endtask

  task automatic run(input string tag, input bit im, input logic [3:0] op, input logic [1:0] ic,
                     input logic [7:0] iv, input logic [31:0] a, input logic [31:0] b, input bit ci);
    logic [31:0] er;
    bit ewe, ec, ecw, en, ez;
    @(posedge clk);
    #1;
    imm_mode = im; op_code = op; imm_code = ic; imm_val = iv;
    rd_val = a; rn_val = b; carry_in = ci;
    @(negedge clk);
    model(er, ewe, ec, ecw);
    en = er[31];
    ez = (er == 0);
    checks++;
    if (result !== er || rd_we !== ewe || flag_c !== ec || c_we !== ecw ||
        flag_n !== en || flag_z !== ez || n_we !== 1'b1 || z_we !== 1'b1) begin
      errors++;
      $display("FAIL %s: actual r=%h we=%b n=%b z=%b c=%b cw=%b nw=%b zw=%b expected r=%h we=%b n=%b z=%b c=%b cw=%b nw=1 zw=1",
               tag, result, rd_we, flag_n, flag_z, flag_c, c_we, n_we, z_we,
               er, ewe, en, ez, ec, ecw);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    run("R6 idle", 0, 4'h0, 0, 0, 32'h0, 32'h0, 0);
    run("R1 and", 0, 4'h0, 0, 0, 32'hF0F0_1234, 32'h0FF0_FFFF, 1);
    run("R1 xor", 0, 4'h1, 0, 0, 32'hAAAA_5555, 32'hFFFF_0000, 0);
    run("R1 or",  0, 4'hC, 0, 0, 32'h8000_0001, 32'h0000_0100, 1);
    run("R1 bic", 0, 4'hE, 0, 0, 32'hFFFF_FFFF, 32'h0000_00F0, 0);
    run("R1 mov", 0, 4'hD, 0, 0, 32'h1234_5678, 32'h0, 1);
    run("R1 mvn", 0, 4'hF, 0, 0, 32'h0, 32'h0000_0000, 0);
    run("R2 add carry", 0, 4'h4, 0, 0, 32'hFFFF_FFFF, 32'h1, 0);
    run("R2 adc", 0, 4'h5, 0, 0, 32'h7FFF_FFFF, 32'h0, 1);
    run("R2 adc wrap", 0, 4'h5, 0, 0, 32'hFFFF_FFFE, 32'h1, 1);
    run("R3 sub noborrow", 0, 4'h2, 0, 0, 32'h10, 32'h10, 0);
    run("R3 sub borrow", 0, 4'h2, 0, 0, 32'h5, 32'h6, 1);
    run("R4 sxb neg", 0, 4'h3, 0, 0, 32'h0, 32'hABCD_EF80, 0);
    run("R4 sxb pos", 0, 4'h3, 0, 0, 32'hFFFF_FFFF, 32'h0000_017F, 1);
    run("R5 tst", 0, 4'h8, 0, 0, 32'hF0, 32'h0F, 1);
    run("R5 teq", 0, 4'h9, 0, 0, 32'h8000_0000, 32'h1, 0);
    run("R5 cmp", 0, 4'hA, 0, 0, 32'h3, 32'h9, 1);
    run("R7 lsr1", 0, 4'h6, 0, 0, 32'h8000_0003, 32'h1, 0);
    run("R7 lsr31", 0, 4'h6, 0, 0, 32'hC000_0000, 32'h1F, 0);
    run("R8 lsl1", 0, 4'h7, 0, 0, 32'h8000_0001, 32'h1, 0);
    run("R8 lsl31", 0, 4'h7, 0, 0, 32'h0000_0003, 32'h1F, 0);
    run("R9 ror1", 0, 4'hB, 0, 0, 32'h0000_0001, 32'h1, 0);
    run("R9 ror8", 0, 4'hB, 0, 0, 32'h1234_5678, 32'h8, 1);
    run("R10 zero amt", 0, 4'h6, 0, 0, 32'hDEAD_BEEF, 32'hFFFF_FFE0, 1);
    run("R10 high bits", 0, 4'h7, 0, 0, 32'h0000_00FF, 32'h0000_0124, 0);
    run("R10 ror zero", 0, 4'hB, 0, 0, 32'h8000_0001, 32'h0, 0);
    run("R11 imm mov", 1, 4'h0, 2'b00, 8'hFF, 32'h1234, 32'hFFFF_FFFF, 1);
    run("R11 imm cmp", 1, 4'h4, 2'b01, 8'h3A, 32'h3A, 32'h0, 0);
    run("R11 imm add", 1, 4'hF, 2'b10, 8'h80, 32'hFFFF_FF80, 32'h5, 0);
    run("R12 imm sub", 1, 4'h8, 2'b11, 8'h01, 32'h0, 32'h0, 1);
    run("R13 hold", 0, 4'hC, 0, 0, 32'h0, 32'h0, 1);
    for (int k = 0; k < 400; k++)
      run("R6 sweep", ($urandom % 4) == 0, 4'($urandom), 2'($urandom), 8'($urandom),
          $urandom, ((k % 3) == 0) ? 32'($urandom % 40) : $urandom, 1'($urandom));
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule